// File: doc/BRIEF.md
# Serial Memory Controller Status and Interrupt Unit

This unit holds the control, status and interrupt registers of a serial-memory controller. A simple register bus (one write strobe, one read strobe, a word address, write data and registered read data) reaches five word locations: a write-only control word, a status word, a mask-set location, a mask-clear location and a mask readback. The serial shifting engine is not part of the unit. Its events arrive as one-cycle input pulses: receive data full, transmit data empty, overrun, chip select rose, chip select fell and instruction end. One level input reports that the transmitter is idle.

Each event pulse latches a pending flag. Software collects these flags by reading the status word, and that read clears them. The interrupt mask has no direct write port. Ones written to the set location turn mask bits on, and ones written to the clear location turn them off. The level interrupt output is raised whenever a status bit and its mask bit are both set.

Strobes in the control word turn the controller on or off, reset its state, or ask the engine to release chip select after the current transfer. A separate completion output reports that both instruction end and chip select rise have been seen. The two events may arrive in different status reads, so they are tracked apart from the clear-on-read flags.

Top module: `qsr_top`

## Requirements
- R1: After reset the status word reads 0 (apart from bit 2, which follows the idle input), the mask reads 0, and irq_o, enabled_o, cmd_done_o, cs_release_o and eng_reset_o are all 0.
- R2: Each event pulse sets its flag at a fixed status bit: 0 receive full, 1 transmit empty, 3 overrun, 8 chip select rose, 9 chip select fell, 10 instruction end. A read of the status word (address 1) returns the flags and clears them, so a second read returns 0 for those bits.
- R3: An event that arrives in the same cycle as a status read does not appear in that read. It stays pending and appears in the next status read.
- R4: Status bit 2 follows tx_idle_i and status bit 24 follows the enabled state. Both are levels, and reads do not clear them.
- R5: Ones written to address 2 set the matching mask bits, and ones written to address 3 clear them. Address 4 returns the mask in the status bit layout. Only bits 0-3, 8-10 and 24 can be set.
- R6: irq_o is 1 exactly when some status bit and its mask bit are both 1.
- R7: In the control word (address 0), bit 0 sets the enabled state and bit 1 clears it. If both bits are written together, the controller ends up disabled.
- R8: Control bit 7 clears every flag, the mask, the enabled state and the completion tracker on the clock edge that takes the write. It also pulses eng_reset_o for one cycle.
- R9: Control bit 24 pulses cs_release_o for one cycle after the write.
- R10: cmd_done_o rises only once both instruction end and chip select rise have been seen since the last completion was taken, even when status reads fall between them. A status read made while cmd_done_o is 1 drops it.
- R11: Read data appears one cycle after the read strobe and holds until the next read. A read of any address other than 1 leaves the flags unchanged. Addresses 0 and 5-7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, registered |
| ev_rx_full_i | input | 1 | Receive data full event pulse |
| ev_tx_empty_i | input | 1 | Transmit data empty event pulse |
| ev_overrun_i | input | 1 | Overrun event pulse |
| ev_cs_rise_i | input | 1 | Chip select rose event pulse |
| ev_cs_fall_i | input | 1 | Chip select fell event pulse |
| ev_inst_end_i | input | 1 | Instruction end event pulse |
| tx_idle_i | input | 1 | Transmitter idle level |
| irq_o | output | 1 | Level interrupt |
| enabled_o | output | 1 | Controller enabled state |
| cs_release_o | output | 1 | Release chip select request pulse |
| eng_reset_o | output | 1 | Engine reset pulse |
| cmd_done_o | output | 1 | Command complete |

## Verification
The flag path is driven with single events, with several events in one cycle, and with an event that lands in the same cycle as a status read. These cases separate correct clear-on-read from clearing too much or latching too late. The mask is built up and torn down with set and clear writes, and the interrupt is sampled each time. This shows that the interrupt follows the AND of status and mask, including the two level bits that a read does not clear. The completion output is driven three ways: instruction end and chip select rise in separate cycles with a status read between them, both in the same cycle, and a read while the output is high. These cases show that completion needs both events and that only a read made after completion consumes it. Control writes with enable alone, disable alone, both together, software reset and release check each strobe in isolation.

// File: rtl/qsr_pkg.sv
package qsr_pkg;
  // register word addresses
  localparam int unsigned A_CTRL = 0;
  localparam int unsigned A_STAT = 1;
  localparam int unsigned A_MSET = 2;
  localparam int unsigned A_MCLR = 3;
  localparam int unsigned A_MASK = 4;

  // status / mask bit positions
  localparam int unsigned B_RXF  = 0;
  localparam int unsigned B_TXE  = 1;
  localparam int unsigned B_IDLE = 2;
  localparam int unsigned B_OVR  = 3;
  localparam int unsigned B_CSR  = 8;
  localparam int unsigned B_CSF  = 9;
  localparam int unsigned B_IEND = 10;
  localparam int unsigned B_EN   = 24;

  // control bit positions
  localparam int unsigned C_ON   = 0;
  localparam int unsigned C_OFF  = 1;
  localparam int unsigned C_RST  = 7;
  localparam int unsigned C_LAST = 24;

  localparam logic [31:0] FLAG_BITS =
    (32'd1 << B_RXF) | (32'd1 << B_TXE) | (32'd1 << B_OVR) |
    (32'd1 << B_CSR) | (32'd1 << B_CSF) | (32'd1 << B_IEND);
  localparam logic [31:0] LEVEL_BITS = (32'd1 << B_IDLE) | (32'd1 << B_EN);
  localparam logic [31:0] MASKABLE   = FLAG_BITS | LEVEL_BITS;
endpackage

// File: rtl/qsr_rst_sync.sv
module qsr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/qsr_ctrl.sv
module qsr_ctrl #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ctrl_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              soft_rst_o,
  output logic              enabled_o,
  output logic              cs_release_o,
  output logic              eng_reset_o
);
  import qsr_pkg::*;

  logic en_q, en_d, en_ce;
  logic rel_q, rel_d;
  logic eng_q, eng_d;
  logic on_w, off_w;

  assign on_w       = wr_ctrl_i & wdata_i[C_ON];
  assign off_w      = wr_ctrl_i & wdata_i[C_OFF];
  assign soft_rst_o = wr_ctrl_i & wdata_i[C_RST];

  // next state: reset beats disable, disable beats enable
  always_comb begin
    en_ce = soft_rst_o | on_w | off_w;
    en_d  = en_q;
    if (soft_rst_o)  en_d = 1'b0;
    else if (off_w)  en_d = 1'b0;
    else if (on_w)   en_d = 1'b1;
    rel_d = wr_ctrl_i & wdata_i[C_LAST];
    eng_d = soft_rst_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      rel_q <= 1'b0;
      eng_q <= 1'b0;
    end else begin
      if (en_ce) en_q <= en_d;
      rel_q <= rel_d;
      eng_q <= eng_d;
    end
  end

  assign enabled_o    = en_q;
  assign cs_release_o = rel_q;
  assign eng_reset_o  = eng_q;
endmodule

// File: rtl/qsr_flags.sv
module qsr_flags #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              rd_clr_i,
  input  logic [DATA_W-1:0] ev_word_i,
  output logic [DATA_W-1:0] pend_o,
  output logic              cmd_done_o
);
  import qsr_pkg::*;

  localparam logic [DATA_W-1:0] FMASK = DATA_W'(FLAG_BITS);

  logic [DATA_W-1:0] pend_q, pend_d;
  logic              pend_ce;
  logic              iend_q, iend_d, csr_q, csr_d, trk_ce;
  logic              done_w, take_w;

  assign done_w = iend_q & csr_q;
  assign take_w = rd_clr_i & done_w;

  always_comb begin
    pend_ce = soft_rst_i | rd_clr_i | (|(ev_word_i & FMASK));
    if (soft_rst_i)
      pend_d = '0;
    else if (rd_clr_i)
      pend_d = ev_word_i & FMASK;
    else
      pend_d = (pend_q | ev_word_i) & FMASK;
  end

  // completion tracker survives status reads until both halves are seen
  always_comb begin
    trk_ce = soft_rst_i | take_w | ev_word_i[B_IEND] | ev_word_i[B_CSR];
    if (soft_rst_i) begin
      iend_d = 1'b0;
      csr_d  = 1'b0;
    end else begin
      iend_d = (iend_q & ~take_w) | ev_word_i[B_IEND];
      csr_d  = (csr_q  & ~take_w) | ev_word_i[B_CSR];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      iend_q <= 1'b0;
      csr_q  <= 1'b0;
    end else begin
      if (pend_ce) pend_q <= pend_d;
      if (trk_ce) begin
        iend_q <= iend_d;
        csr_q  <= csr_d;
      end
    end
  end

  assign pend_o     = pend_q;
  assign cmd_done_o = done_w;
endmodule

// File: rtl/qsr_mask.sv
module qsr_mask #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] mask_o
);
  import qsr_pkg::*;

  localparam logic [DATA_W-1:0] VALID = DATA_W'(MASKABLE);

  logic [DATA_W-1:0] mask_q, mask_d, set_w, clr_w;
  logic              mask_ce;

  always_comb begin
    set_w   = set_i ? wdata_i : '0;
    clr_w   = clr_i ? wdata_i : '0;
    mask_ce = soft_rst_i | set_i | clr_i;
    if (soft_rst_i) mask_d = '0;
    else            mask_d = ((mask_q | set_w) & ~clr_w) & VALID;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '0;
    else if (mask_ce) mask_q <= mask_d;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/qsr_top.sv
module qsr_top #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              ev_rx_full_i,
  input  logic              ev_tx_empty_i,
  input  logic              ev_overrun_i,
  input  logic              ev_cs_rise_i,
  input  logic              ev_cs_fall_i,
  input  logic              ev_inst_end_i,
  input  logic              tx_idle_i,
  output logic              irq_o,
  output logic              enabled_o,
  output logic              cs_release_o,
  output logic              eng_reset_o,
  output logic              cmd_done_o
);
  import qsr_pkg::*;

  logic              rst_ns;
  logic              wr_ctrl, wr_set, wr_clr, rd_stat;
  logic              soft_rst;
  logic [DATA_W-1:0] ev_word, pend_w, mask_w, status_w;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  qsr_rst_sync #(.STAGES(2)) u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_ns)
  );

  // address decode
  assign wr_ctrl = wr_i & (addr_i == ADDR_W'(A_CTRL));
  assign wr_set  = wr_i & (addr_i == ADDR_W'(A_MSET));
  assign wr_clr  = wr_i & (addr_i == ADDR_W'(A_MCLR));
  assign rd_stat = rd_i & (addr_i == ADDR_W'(A_STAT));

  always_comb begin
    ev_word         = '0;
    ev_word[B_RXF]  = ev_rx_full_i;
    ev_word[B_TXE]  = ev_tx_empty_i;
    ev_word[B_OVR]  = ev_overrun_i;
    ev_word[B_CSR]  = ev_cs_rise_i;
    ev_word[B_CSF]  = ev_cs_fall_i;
    ev_word[B_IEND] = ev_inst_end_i;
  end

  qsr_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ns),
    .wr_ctrl_i   (wr_ctrl),
    .wdata_i     (wdata_i),
    .soft_rst_o  (soft_rst),
    .enabled_o   (enabled_o),
    .cs_release_o(cs_release_o),
    .eng_reset_o (eng_reset_o)
  );

  qsr_flags #(.DATA_W(DATA_W)) u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ns),
    .soft_rst_i(soft_rst),
    .rd_clr_i  (rd_stat),
    .ev_word_i (ev_word),
    .pend_o    (pend_w),
    .cmd_done_o(cmd_done_o)
  );

  qsr_mask #(.DATA_W(DATA_W)) u_mask (
    .clk_i     (clk_i),
    .rst_ni    (rst_ns),
    .soft_rst_i(soft_rst),
    .set_i     (wr_set),
    .clr_i     (wr_clr),
    .wdata_i   (wdata_i),
    .mask_o    (mask_w)
  );

  always_comb begin
    status_w         = pend_w;
    status_w[B_IDLE] = tx_idle_i;
    status_w[B_EN]   = enabled_o;
  end

  always_comb begin
    case (addr_i)
      ADDR_W'(A_STAT): rdata_d = status_w;
      ADDR_W'(A_MASK): rdata_d = mask_w;
      default:         rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ns) begin
    if (!rst_ns)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;
  assign irq_o   = |(status_w & mask_w);
endmodule

// File: rtl/qsr_chk.sv
module qsr_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk_i,
  input logic              rst_ns,
  input logic              wr_i,
  input logic              rd_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] status_w,
  input logic [DATA_W-1:0] mask_w,
  input logic              ev_any,
  input logic              ev_inst_end_i,
  input logic              ev_cs_rise_i,
  input logic              irq_o,
  input logic              enabled_o,
  input logic              cs_release_o,
  input logic              cmd_done_o
);
  import qsr_pkg::*;

  logic wr_ctrl_c;
  assign wr_ctrl_c = wr_i && (addr_i == ADDR_W'(A_CTRL));

  // R8
  swrst_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ns)
    (wr_ctrl_c && wdata_i[C_RST]) |=> (mask_w == '0 && !enabled_o && !irq_o && !cmd_done_o));

  // R7
  disable_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ns)
    (wr_ctrl_c && wdata_i[C_OFF]) |=> !enabled_o);

  // R9
  release_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ns)
    cs_release_o |-> $past(wr_ctrl_c && wdata_i[C_LAST]));

  // R2
  read_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ns)
    (rd_i && addr_i == ADDR_W'(A_STAT) && !ev_any)
      |=> ((status_w & DATA_W'(FLAG_BITS)) == '0));

  // R6
  mask_off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ns)
    (wr_i && addr_i == ADDR_W'(A_MCLR) && wdata_i == '1) |=> !irq_o);

  // R10
  done_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ns)
    $rose(cmd_done_o) |-> ($past(ev_inst_end_i) || $past(ev_cs_rise_i)));
endmodule

bind qsr_top qsr_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ns       (rst_ns),
  .wr_i         (wr_i),
  .rd_i         (rd_i),
  .addr_i       (addr_i),
  .wdata_i      (wdata_i),
  .status_w     (status_w),
  .mask_w       (mask_w),
  .ev_any       (|ev_word),
  .ev_inst_end_i(ev_inst_end_i),
  .ev_cs_rise_i (ev_cs_rise_i),
  .irq_o        (irq_o),
  .enabled_o    (enabled_o),
  .cs_release_o (cs_release_o),
  .cmd_done_o   (cmd_done_o)
);

// File: tb/sim_qsr_top.sv
`timescale 1ns/1ps
module sim_qsr_top;
  localparam int DW = 32;
  localparam int AW = 3;

  localparam logic [1:0] K_NOP = 2'd0;
  localparam logic [1:0] K_WR  = 2'd1;
  localparam logic [1:0] K_RD  = 2'd2;

  typedef struct packed {
    logic [1:0]  kind;
    logic [2:0]  addr;
    logic [31:0] data;
    logic [31:0] evw;
    logic [31:0] exp;
    logic        irq;
    logic [3:0]  req;
  } vec_t;

  // addresses: 0 ctrl, 1 status, 2 mask set, 3 mask clear, 4 mask read
  localparam int NV = 25;
  localparam vec_t VT [NV] = '{
    '{K_RD,  3'd1, 32'h0,        32'h0,   32'h0,        1'b0, 4'd1},  // R1 status 0
    '{K_RD,  3'd4, 32'h0,        32'h0,   32'h0,        1'b0, 4'd1},  // R1 mask 0
    '{K_WR,  3'd0, 32'h1,        32'h0,   32'h0,        1'b0, 4'd7},  // R7 enable
    '{K_RD,  3'd1, 32'h0,        32'h0,   32'h01000000, 1'b0, 4'd4},  // R4 en bit
    '{K_NOP, 3'd0, 32'h0,        32'h1,   32'h0,        1'b0, 4'd6},  // R6 rx masked off
    '{K_RD,  3'd4, 32'h0,        32'h0,   32'h0,        1'b0, 4'd11}, // R11 no clear
    '{K_RD,  3'd1, 32'h0,        32'h0,   32'h01000001, 1'b0, 4'd2},  // R2 rx seen
    '{K_RD,  3'd1, 32'h0,        32'h0,   32'h01000000, 1'b0, 4'd2},  // R2 rx cleared
    '{K_WR,  3'd2, 32'h00000500, 32'h0,   32'h0,        1'b0, 4'd5},  // R5 set
    '{K_RD,  3'd4, 32'h0,        32'h0,   32'h00000500, 1'b0, 4'd5},  // R5 read
    '{K_NOP, 3'd0, 32'h0,        32'h400, 32'h0,        1'b1, 4'd6},  // R6 iend irq
    '{K_WR,  3'd3, 32'h00000400, 32'h0,   32'h0,        1'b0, 4'd5},  // R5 clear
    '{K_RD,  3'd4, 32'h0,        32'h0,   32'h00000100, 1'b0, 4'd5},  // R5 read
    '{K_RD,  3'd1, 32'h0,        32'h100, 32'h01000400, 1'b1, 4'd3},  // R3 csr with read
    '{K_RD,  3'd1, 32'h0,        32'h0,   32'h01000100, 1'b0, 4'd3},  // R3 csr later
    '{K_NOP, 3'd0, 32'h0,        32'h20A, 32'h0,        1'b0, 4'd6},  // R6 unmasked evts
    '{K_RD,  3'd1, 32'h0,        32'h0,   32'h0100020A, 1'b0, 4'd2},  // R2 multi
    '{K_WR,  3'd2, 32'h01000000, 32'h0,   32'h0,        1'b1, 4'd4},  // R4 en masked
    '{K_RD,  3'd1, 32'h0,        32'h0,   32'h01000000, 1'b1, 4'd4},  // R4 level kept
    '{K_WR,  3'd0, 32'h3,        32'h0,   32'h0,        1'b0, 4'd7},  // R7 both
    '{K_RD,  3'd1, 32'h0,        32'h0,   32'h0,        1'b0, 4'd7},  // R7 off
    '{K_WR,  3'd0, 32'h1,        32'h0,   32'h0,        1'b1, 4'd7},  // R7 on
    '{K_WR,  3'd0, 32'h2,        32'h0,   32'h0,        1'b0, 4'd7},  // R7 off
    '{K_WR,  3'd3, 32'hFFFFFFFF, 32'h0,   32'h0,        1'b0, 4'd5},  // R5 clear all
    '{K_RD,  3'd4, 32'h0,        32'h0,   32'h0,        1'b0, 4'd5}   // R5 empty
  };

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic          wr_i, rd_i;
  logic [AW-1:0] addr_i;
  logic [DW-1:0] wdata_i, rdata_o;
  logic          ev_rx_full_i, ev_tx_empty_i, ev_overrun_i;
  logic          ev_cs_rise_i, ev_cs_fall_i, ev_inst_end_i, tx_idle_i;
  logic          irq_o, enabled_o, cs_release_o, eng_reset_o, cmd_done_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk_i = ~clk_i;

  qsr_top #(.DATA_W(DW), .ADDR_W(AW)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .rd_i(rd_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .ev_rx_full_i(ev_rx_full_i), .ev_tx_empty_i(ev_tx_empty_i),
    .ev_overrun_i(ev_overrun_i), .ev_cs_rise_i(ev_cs_rise_i),
    .ev_cs_fall_i(ev_cs_fall_i), .ev_inst_end_i(ev_inst_end_i),
    .tx_idle_i(tx_idle_i), .irq_o(irq_o), .enabled_o(enabled_o),
    .cs_release_o(cs_release_o), .eng_reset_o(eng_reset_o),
    .cmd_done_o(cmd_done_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic idle_in();
    wr_i = 1'b0; rd_i = 1'b0; addr_i = '0; wdata_i = '0;
    ev_rx_full_i = 1'b0; ev_tx_empty_i = 1'b0; ev_overrun_i = 1'b0;
    ev_cs_rise_i = 1'b0; ev_cs_fall_i = 1'b0; ev_inst_end_i = 1'b0;
  endtask

  // drive at a negedge, let one posedge pass, return at the next negedge
  task automatic step(input logic [1:0] kind, input logic [2:0] a,
                      input logic [31:0] d, input logic [31:0] ev);
    wr_i          = (kind == K_WR);
    rd_i          = (kind == K_RD);
    addr_i        = a;
    wdata_i       = d;
    ev_rx_full_i  = ev[0];
    ev_tx_empty_i = ev[1];
    ev_overrun_i  = ev[3];
    ev_cs_rise_i  = ev[8];
    ev_cs_fall_i  = ev[9];
    ev_inst_end_i = ev[10];
    @(negedge clk_i);
    idle_in();
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle_in();
    tx_idle_i = 1'b0;
    rst_ni = 1'b0;
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);

    // R1 reset outputs
    chk("R1", "irq", 32'(irq_o), 32'd0);
    chk("R1", "enabled", 32'(enabled_o), 32'd0);
    chk("R1", "cmd_done", 32'(cmd_done_o), 32'd0);
    chk("R1", "release", 32'(cs_release_o), 32'd0);
    chk("R1", "eng_reset", 32'(eng_reset_o), 32'd0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d", VT[i].req);
      step(VT[i].kind, VT[i].addr, VT[i].data, VT[i].evw);
      chk(tag, $sformatf("vec %0d irq", i), 32'(irq_o), 32'(VT[i].irq));
      if (VT[i].kind == K_RD)
        chk(tag, $sformatf("vec %0d rdata", i), rdata_o, VT[i].exp);
    end

    // R4 idle level at bit 2, not cleared
    tx_idle_i = 1'b1;
    step(K_RD, 3'd1, 32'h0, 32'h0);
    chk("R4", "idle read 1", rdata_o, 32'h4);
    step(K_RD, 3'd1, 32'h0, 32'h0);
    chk("R4", "idle read 2", rdata_o, 32'h4);
    tx_idle_i = 1'b0;

    // R11 unmapped and control reads return 0; hold between reads
    step(K_RD, 3'd6, 32'h0, 32'h0);
    chk("R11", "unmapped", rdata_o, 32'h0);
    step(K_WR, 3'd2, 32'h1, 32'h0);
    step(K_RD, 3'd4, 32'h0, 32'h0);
    step(K_NOP, 3'd0, 32'h0, 32'h0);
    chk("R11", "hold", rdata_o, 32'h1);
    step(K_RD, 3'd0, 32'h0, 32'h0);
    chk("R11", "ctrl reads 0", rdata_o, 32'h0);

    // R10 completion across reads
    step(K_NOP, 3'd0, 32'h0, 32'h400);
    chk("R10", "iend only", 32'(cmd_done_o), 32'd0);
    step(K_RD, 3'd1, 32'h0, 32'h0);
    chk("R10", "after read", 32'(cmd_done_o), 32'd0);
    step(K_NOP, 3'd0, 32'h0, 32'h100);
    chk("R10", "csr later", 32'(cmd_done_o), 32'd1);
    step(K_NOP, 3'd0, 32'h0, 32'h0);
    chk("R10", "held", 32'(cmd_done_o), 32'd1);
    step(K_RD, 3'd1, 32'h0, 32'h0);
    chk("R10", "taken", 32'(cmd_done_o), 32'd0);
    step(K_NOP, 3'd0, 32'h0, 32'h500);
    chk("R10", "both at once", 32'(cmd_done_o), 32'd1);
    step(K_RD, 3'd1, 32'h0, 32'h0);

    // R9 release pulse
    step(K_WR, 3'd0, 32'h01000000, 32'h0);
    chk("R9", "pulse", 32'(cs_release_o), 32'd1);
    step(K_NOP, 3'd0, 32'h0, 32'h0);
    chk("R9", "one cycle", 32'(cs_release_o), 32'd0);

    // R8 software reset
    step(K_WR, 3'd0, 32'h1, 32'h0);
    step(K_NOP, 3'd0, 32'h0, 32'h501);
    chk("R8", "irq before", 32'(irq_o), 32'd1);
    step(K_WR, 3'd0, 32'h80, 32'h0);
    chk("R8", "irq", 32'(irq_o), 32'd0);
    chk("R8", "enabled", 32'(enabled_o), 32'd0);
    chk("R8", "cmd_done", 32'(cmd_done_o), 32'd0);
    chk("R8", "eng pulse", 32'(eng_reset_o), 32'd1);
    step(K_RD, 3'd4, 32'h0, 32'h0);
    chk("R8", "eng one cycle", 32'(eng_reset_o), 32'd0);
    chk("R8", "mask", rdata_o, 32'h0);
    step(K_RD, 3'd1, 32'h0, 32'h0);
    chk("R8", "status", rdata_o, 32'h0);

    // R1 reset reapplied mid-run
    step(K_WR, 3'd2, 32'h01000000, 32'h0);
    step(K_WR, 3'd0, 32'h1, 32'h0);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk("R1", "enabled after reset", 32'(enabled_o), 32'd0);
    chk("R1", "irq after reset", 32'(irq_o), 32'd0);
    step(K_RD, 3'd4, 32'h0, 32'h0);
    chk("R1", "mask after reset", rdata_o, 32'h0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule